// File: doc/BRIEF.md
# Timer Bus Interface and Control Decoder

This block sits between an 8-bit processor bus and a three-channel down-counter timer. The bus is synchronous to `clk`. Each clock cycle in which the chip select and a strobe are both low counts as one access. The block decodes the two address lines into a counter port or the control port. It splits the incoming control byte into per-channel mode, byte-access format and decimal-count fields. It assembles one or two written bytes into a 16-bit count, and it signals that count to the owning channel with a one-cycle load pulse.

On reads, the block picks between the channel's running count and a value held by an external latch stage. It returns the low or high byte according to the channel's format and its own byte toggle. Each channel keeps separate toggles for writes and for reads. A write to the control port is routed to a channel by the select field inside the byte, not by the address. A control byte whose format field is zero is a latch command: it only raises a request pulse towards the latch stage.

Top module: `tmr_bus_if`

## Requirements
- R1: With `cs_n` low, address 0, 1 or 2 reaches counter port 0, 1 or 2, and address 3 reaches the control port. With `cs_n` high, an access changes no state and raises no pulse.
- R2: A control-port write uses bits 7:6 as the channel select, bits 5:4 as the format, bits 3:1 as the mode and bit 0 as the decimal flag. Select value 3 is ignored. A stored write raises `cfg_stb` for that channel in the next cycle.
- R3: A mode code of 6 or 7 is stored as 2 or 3. Codes 0 to 5 are stored unchanged, so a stored mode never exceeds 5.
- R4: A control byte with format 00 pulses `lat_req` of the selected channel in the next cycle. It leaves that channel's configuration and toggles unchanged.
- R5: A stored control write clears that channel's write and read toggles, so the next data write and the next read both take the low byte.
- R6: In format 01, a data write loads {8'h00, byte}. In format 10, it loads {byte, 8'h00}. In both cases `load_stb` pulses in the next cycle, and at most one channel pulses at a time.
- R7: In format 11, the first data write is held and raises no pulse. The second loads {second, first} with a single `load_stb` pulse.
- R8: A channel with format 00 (its state after reset) ignores data writes, and its reads return the low byte.
- R9: Reads return the low byte in format 01 and the high byte in format 10. In format 11 they alternate, low byte first.
- R10: Read data comes from `lat_val` while that channel's `lat_vld` is high, and from `live_cnt` otherwise. A read of the last byte of a latched value pulses `lat_done` in the next cycle.
- R11: `dout_oe` is high only while `cs_n` and `rd_n` are low and `wr_n` is high. `dout` is zero whenever it is not driven. A read of address 3 drives 8'h00. When a read and a write happen together, only the write acts.
- R12: After reset, all modes, formats, decimal flags and toggles are zero, and no pulse or bus drive is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| live_cnt | input | NCH*16 | Running count of each channel |
| lat_vld | input | NCH | Latched value present, per channel |
| lat_val | input | NCH*16 | Latched value of each channel |
| ch_mode | output | NCH*3 | Stored mode per channel |
| ch_fmt | output | NCH*2 | Stored byte-access format per channel |
| ch_bcd | output | NCH | Stored decimal flag per channel |
| cfg_stb | output | NCH | Control byte stored, one cycle |
| load_stb | output | NCH | New count ready, one cycle |
| load_val | output | NCH*16 | Count to load, valid with `load_stb` |
| lat_req | output | NCH | Latch command, one cycle |
| lat_done | output | NCH | Last latched byte read, one cycle |

## Verification
The checker assumes that `cs_n`, `rd_n` and `wr_n` are held high while reset is applied. It also assumes that every strobe lasts exactly one clock cycle, so that each low cycle counts as one access. The bench drives all bus inputs on the falling clock edge and keeps them for one full cycle. It returns to idle between accesses, and it changes `live_cnt`, `lat_val` and `lat_vld` only while the bus is idle. Simultaneous read and write strobes are applied on purpose, since R11 defines the outcome.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int FMT_W  = 2;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 2'd3;

    typedef enum logic [FMT_W-1:0] {
        FMT_NONE = 2'b00,
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_BOTH = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        fmt_e              fmt;
        logic              bcd;
    } chan_cfg_t;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                  cs_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     ctl_byte,
    output logic [NCH-1:0]        cfg_we,
    output logic [NCH-1:0]        lat_cmd,
    output logic [NCH-1:0]        dat_we,
    output logic [NCH-1:0]        rd_acc,
    output logic                  bus_drv
);
    logic wr_act;
    logic rd_act;
    logic ctl_wr;

    assign wr_act  = !cs_n && !wr_n;
    assign rd_act  = !cs_n && !rd_n && wr_n;
    assign ctl_wr  = wr_act && (addr == CTL_ADDR);
    assign bus_drv = rd_act;

    always_comb begin
        cfg_we  = '0;
        lat_cmd = '0;
        dat_we  = '0;
        rd_acc  = '0;
        for (int i = 0; i < NCH; i++) begin
            dat_we[i] = wr_act && (addr == ADDR_W'(i));
            rd_acc[i] = rd_act && (addr == ADDR_W'(i));
            if (ctl_wr && (ctl_byte[7:6] == ADDR_W'(i))) begin
                if (ctl_byte[5:4] == FMT_NONE) begin
                    lat_cmd[i] = 1'b1;
                end else begin
                    cfg_we[i]  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_chan_acc.sv
module tmr_chan_acc
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               lat_cmd,
    input  logic               dat_we,
    input  logic               rd_acc,
    input  logic [BYTE_W-1:0]  din,
    input  logic [CNT_W-1:0]   live,
    input  logic               lat_vld,
    input  logic [CNT_W-1:0]   lat_val,
    output logic [MODE_W-1:0]  mode,
    output logic [FMT_W-1:0]   fmt,
    output logic               bcd,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic [CNT_W-1:0]   load_val,
    output logic               load_stb,
    output logic               cfg_stb,
    output logic               lat_req,
    output logic               lat_done
);
    typedef struct packed {
        chan_cfg_t          cfg;
        logic               wtog;
        logic               rtog;
        logic [BYTE_W-1:0]  lo_hold;
        logic [CNT_W-1:0]   load_val;
        logic               load_stb;
        logic               cfg_stb;
        logic               lat_req;
        logic               lat_done;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [CNT_W-1:0]  src;
    logic              take_hi;
    logic              last_rd;
    logic [MODE_W-1:0] wmode;

    assign src     = lat_vld ? lat_val : live;
    assign take_hi = (st_q.cfg.fmt == FMT_HI) || ((st_q.cfg.fmt == FMT_BOTH) && st_q.rtog);
    assign last_rd = (st_q.cfg.fmt != FMT_BOTH) || st_q.rtog;
    assign wmode   = din[3:1];
    assign rd_byte = take_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

    always_comb begin
        st_d          = st_q;
        st_d.load_stb = 1'b0;
        st_d.cfg_stb  = 1'b0;
        st_d.lat_req  = 1'b0;
        st_d.lat_done = 1'b0;
        if (cfg_we) begin
            st_d.cfg.mode = wmode[1] ? {1'b0, wmode[1:0]} : wmode;
            st_d.cfg.fmt  = fmt_e'(din[5:4]);
            st_d.cfg.bcd  = din[0];
            st_d.wtog     = 1'b0;
            st_d.rtog     = 1'b0;
            st_d.cfg_stb  = 1'b1;
        end
        if (lat_cmd) begin
            st_d.lat_req = 1'b1;
        end
        if (dat_we) begin
            unique case (st_q.cfg.fmt)
                FMT_LO: begin
                    st_d.load_val = {{BYTE_W{1'b0}}, din};
                    st_d.load_stb = 1'b1;
                end
                FMT_HI: begin
                    st_d.load_val = {din, {BYTE_W{1'b0}}};
                    st_d.load_stb = 1'b1;
                end
                FMT_BOTH: begin
                    if (!st_q.wtog) begin
                        st_d.lo_hold = din;
                        st_d.wtog    = 1'b1;
                    end else begin
                        st_d.load_val = {din, st_q.lo_hold};
                        st_d.load_stb = 1'b1;
                        st_d.wtog     = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (rd_acc) begin
            if (st_q.cfg.fmt == FMT_BOTH) begin
                st_d.rtog = !st_q.rtog;
            end
            st_d.lat_done = lat_vld && last_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.cfg.mode;
    assign fmt      = st_q.cfg.fmt;
    assign bcd      = st_q.cfg.bcd;
    assign load_val = st_q.load_val;
    assign load_stb = st_q.load_stb;
    assign cfg_stb  = st_q.cfg_stb;
    assign lat_req  = st_q.lat_req;
    assign lat_done = st_q.lat_done;
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [1:0]              addr,
    input  logic [7:0]              din,
    output logic [7:0]              dout,
    output logic                    dout_oe,
    input  logic [NCH*16-1:0]       live_cnt,
    input  logic [NCH-1:0]          lat_vld,
    input  logic [NCH*16-1:0]       lat_val,
    output logic [NCH*3-1:0]        ch_mode,
    output logic [NCH*2-1:0]        ch_fmt,
    output logic [NCH-1:0]          ch_bcd,
    output logic [NCH-1:0]          cfg_stb,
    output logic [NCH-1:0]          load_stb,
    output logic [NCH*16-1:0]       load_val,
    output logic [NCH-1:0]          lat_req,
    output logic [NCH-1:0]          lat_done
);
    logic [NCH-1:0]    cfg_we;
    logic [NCH-1:0]    lat_cmd;
    logic [NCH-1:0]    dat_we;
    logic [NCH-1:0]    rd_acc;
    logic              bus_drv;
    logic [BYTE_W-1:0] rd_byte [NCH];

    tmr_addr_dec #(.NCH(NCH)) u_dec (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .ctl_byte (din),
        .cfg_we   (cfg_we),
        .lat_cmd  (lat_cmd),
        .dat_we   (dat_we),
        .rd_acc   (rd_acc),
        .bus_drv  (bus_drv)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan_acc u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[g]),
            .lat_cmd  (lat_cmd[g]),
            .dat_we   (dat_we[g]),
            .rd_acc   (rd_acc[g]),
            .din      (din),
            .live     (live_cnt[g*CNT_W +: CNT_W]),
            .lat_vld  (lat_vld[g]),
            .lat_val  (lat_val[g*CNT_W +: CNT_W]),
            .mode     (ch_mode[g*MODE_W +: MODE_W]),
            .fmt      (ch_fmt[g*FMT_W +: FMT_W]),
            .bcd      (ch_bcd[g]),
            .rd_byte  (rd_byte[g]),
            .load_val (load_val[g*CNT_W +: CNT_W]),
            .load_stb (load_stb[g]),
            .cfg_stb  (cfg_stb[g]),
            .lat_req  (lat_req[g]),
            .lat_done (lat_done[g])
        );
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_acc[i]) begin
                dout = rd_byte[i];
            end
        end
    end

    assign dout_oe = bus_drv;
endmodule

// File: rtl/tmr_bus_if_chk.sv
module tmr_bus_if_chk #(
    parameter int NCH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                rd_n,
    input logic                wr_n,
    input logic [1:0]          addr,
    input logic [7:0]          dout,
    input logic                dout_oe,
    input logic [NCH-1:0]      lat_vld,
    input logic [NCH*3-1:0]    ch_mode,
    input logic [NCH*2-1:0]    ch_fmt,
    input logic [NCH-1:0]      cfg_stb,
    input logic [NCH-1:0]      load_stb,
    input logic [NCH*16-1:0]   load_val,
    input logic [NCH-1:0]      lat_req,
    input logic [NCH-1:0]      lat_done
);
    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!cs_n && !rd_n && wr_n)); // R11
    AST_DOUT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == 8'h00)); // R11
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb)); // R6
    AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb != '0) |-> $past(!cs_n && !wr_n && addr != 2'd3)); // R1
    AST_CFG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stb != '0) |-> $past(!cs_n && !wr_n && addr == 2'd3)); // R2
    AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (load_stb == '0 && cfg_stb == '0 && lat_req == '0 && lat_done == '0)); // R1

    for (genvar g = 0; g < NCH; g++) begin : g_ast
        AST_LO_ONLY_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (load_stb[g] && ch_fmt[g*2 +: 2] == 2'b01) |-> (load_val[g*16+8 +: 8] == 8'h00)); // R6
        AST_HI_ONLY_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (load_stb[g] && ch_fmt[g*2 +: 2] == 2'b10) |-> (load_val[g*16 +: 8] == 8'h00)); // R6
        AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_mode[g*3 +: 3] <= 3'd5); // R3
        AST_DONE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            lat_done[g] |-> $past(lat_vld[g] && !cs_n && !rd_n)); // R10
    end
endmodule

bind tmr_bus_if tmr_bus_if_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .lat_vld  (lat_vld),
    .ch_mode  (ch_mode),
    .ch_fmt   (ch_fmt),
    .cfg_stb  (cfg_stb),
    .load_stb (load_stb),
    .load_val (load_val),
    .lat_req  (lat_req),
    .lat_done (lat_done)
);

// File: tb/sim_tmr_bus_if.sv
module sim_tmr_bus_if;
    localparam int NCH = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, cs_n, rd_n, wr_n;
    logic [1:0]        addr;
    logic [7:0]        din, dout;
    logic              dout_oe;
    logic [NCH*16-1:0] live_cnt, lat_val, load_val;
    logic [NCH-1:0]    lat_vld, ch_bcd, cfg_stb, load_stb, lat_req, lat_done;
    logic [NCH*3-1:0]  ch_mode;
    logic [NCH*2-1:0]  ch_fmt;

    tmr_bus_if #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .live_cnt(live_cnt), .lat_vld(lat_vld), .lat_val(lat_val),
        .ch_mode(ch_mode), .ch_fmt(ch_fmt), .ch_bcd(ch_bcd), .cfg_stb(cfg_stb),
        .load_stb(load_stb), .load_val(load_val), .lat_req(lat_req), .lat_done(lat_done)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [2:0]  m_mode [NCH];
    logic [1:0]  m_fmt  [NCH];
    logic        m_bcd  [NCH];
    logic        m_wt   [NCH];
    logic        m_rt   [NCH];
    logic [7:0]  m_lo   [NCH];
    logic [15:0] e_val  [NCH];
    logic [NCH-1:0] e_stb, e_cfg, e_lreq, e_ldone;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] stored_mode(logic [2:0] code);
        return (code >= 3'd6) ? code - 3'd4 : code;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = '0; m_fmt[c] = '0; m_bcd[c] = 0;
            m_wt[c] = 0; m_rt[c] = 0; m_lo[c] = '0;
        end
    endtask

    task automatic model_wr(logic [1:0] a, logic [7:0] d);
        int s;
        if (a == 2'd3) begin
            s = int'(d[7:6]);
            if (s < NCH) begin
                if (d[5:4] == 2'b00) begin
                    e_lreq[s] = 1'b1;
                end else begin
                    m_fmt[s] = d[5:4]; m_mode[s] = stored_mode(d[3:1]); m_bcd[s] = d[0];
                    m_wt[s] = 0; m_rt[s] = 0; e_cfg[s] = 1'b1;
                end
            end
        end else begin
            case (m_fmt[a])
                2'b01: begin e_stb[a] = 1'b1; e_val[a] = {8'h00, d}; end
                2'b10: begin e_stb[a] = 1'b1; e_val[a] = {d, 8'h00}; end
                2'b11: begin
                    if (!m_wt[a]) begin m_lo[a] = d; m_wt[a] = 1; end
                    else begin e_stb[a] = 1'b1; e_val[a] = {d, m_lo[a]}; m_wt[a] = 0; end
                end
                default: ;
            endcase
        end
    endtask

    task automatic check_cfg(string req);
        logic [NCH*3-1:0] em;
        logic [NCH*2-1:0] ef;
        logic [NCH-1:0]   eb;
        for (int c = 0; c < NCH; c++) begin
            em[c*3 +: 3] = m_mode[c]; ef[c*2 +: 2] = m_fmt[c]; eb[c] = m_bcd[c];
        end
        check({req, " R3 mode"}, 32'(ch_mode), 32'(em));
        check({req, " R2 format"}, 32'(ch_fmt), 32'(ef));
        check({req, " R2 bcd"}, 32'(ch_bcd), 32'(eb));
    endtask

    // quiet: cs_n high; both: read strobe also low
    task automatic do_wr(logic [1:0] a, logic [7:0] d, bit quiet, bit both);
        e_stb = '0; e_cfg = '0; e_lreq = '0;
        cs_n = quiet; wr_n = 1'b0; rd_n = !both; addr = a; din = d;
        if (!quiet) model_wr(a, d);
        #1;
        check("R11 oe during write", 32'(dout_oe), 32'd0);
        @(negedge clk);
        check("R6/R7 load strobe", 32'(load_stb), 32'(e_stb));
        for (int c = 0; c < NCH; c++)
            if (e_stb[c]) check("R6/R7 load value", 32'(load_val[c*16 +: 16]), 32'(e_val[c]));
        check("R2 cfg strobe", 32'(cfg_stb), 32'(e_cfg));
        check("R4 latch request", 32'(lat_req), 32'(e_lreq));
        check_cfg(quiet ? "R1 unselected" : "R5 after write");
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic do_rd(logic [1:0] a, bit quiet);
        logic [15:0] src;
        logic [7:0]  eb;
        logic        hi, last;
        e_ldone = '0; eb = 8'h00;
        cs_n = quiet; rd_n = 1'b0; wr_n = 1'b1; addr = a;
        if (!quiet && a != 2'd3) begin
            src  = lat_vld[a] ? lat_val[a*16 +: 16] : live_cnt[a*16 +: 16];
            hi   = (m_fmt[a] == 2'b10) || (m_fmt[a] == 2'b11 && m_rt[a]);
            last = (m_fmt[a] != 2'b11) || m_rt[a];
            eb   = hi ? src[15:8] : src[7:0];
            if (m_fmt[a] == 2'b11) m_rt[a] = !m_rt[a];
            e_ldone[a] = lat_vld[a] && last;
        end
        #1;
        check(quiet ? "R1 oe unselected" : "R11 oe on read", 32'(dout_oe), quiet ? 32'd0 : 32'd1);
        check("R9/R10 read byte", 32'(dout), 32'(eb));
        @(negedge clk);
        check("R10 latch done", 32'(lat_done), 32'(e_ldone));
        check("R1 no load on read", 32'(load_stb), 32'd0);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
        live_cnt = '0; lat_val = '0; lat_vld = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 mode", 32'(ch_mode), 32'd0);
        check("R12 format", 32'(ch_fmt), 32'd0);
        check("R12 strobes", 32'({cfg_stb, load_stb, lat_req, lat_done}), 32'd0);
        check("R12 oe", 32'(dout_oe), 32'd0);

        // R8 unconfigured channel
        live_cnt[2*16 +: 16] = 16'h4A42;
        do_wr(2'd2, 8'h11, 0, 0);
        do_rd(2'd2, 0);

        // R7 two-byte load on channel 0, mode 2
        do_wr(2'd3, 8'b00_11_010_0, 0, 0);
        do_wr(2'd0, 8'h34, 0, 0);
        do_wr(2'd0, 8'h12, 0, 0);
        // R3 mode 7 stored as 3; R6 low only
        do_wr(2'd3, 8'b01_01_111_1, 0, 0);
        do_wr(2'd1, 8'hAB, 0, 0);
        // R6 high only
        do_wr(2'd3, 8'b10_10_100_0, 0, 0);
        do_wr(2'd2, 8'hCD, 0, 0);
        // R5 control write mid-pair restarts at low byte
        do_wr(2'd0, 8'h55, 0, 0);
        do_wr(2'd3, 8'b00_11_110_0, 0, 0);
        do_wr(2'd0, 8'h66, 0, 0);
        do_wr(2'd0, 8'h77, 0, 0);
        // R4 latch command
        do_wr(2'd3, 8'b00_00_101_1, 0, 0);
        // R2 select 3 ignored
        do_wr(2'd3, 8'b11_11_001_1, 0, 0);
        // R9 live read, low then high
        live_cnt[0 +: 16] = 16'hBEEF;
        do_rd(2'd0, 0);
        do_rd(2'd0, 0);
        // R10 latched read with done pulse
        lat_vld[0] = 1'b1; lat_val[0 +: 16] = 16'h1357;
        do_rd(2'd0, 0);
        do_rd(2'd0, 0);
        lat_vld = '0;
        // R1 unselected accesses, R11 control read and read with write
        do_wr(2'd1, 8'h99, 1, 0);
        do_rd(2'd1, 1);
        do_rd(2'd3, 0);
        do_wr(2'd1, 8'h5A, 0, 1);

        for (int k = 0; k < 1500; k++) begin
            int op;
            live_cnt = {$urandom, $urandom};
            lat_val  = {$urandom, $urandom};
            lat_vld  = (($urandom % 4) == 0) ? 3'($urandom) : '0;
            op = int'($urandom % 10);
            case (op)
                0, 1, 2: do_wr(2'd3, 8'($urandom), 0, 0);
                3, 4, 5: do_wr(2'($urandom % 3), 8'($urandom), 0, 0);
                6, 7:    do_rd(2'($urandom % 4), 0);
                8: begin
                    if ($urandom % 2) do_wr(2'($urandom), 8'($urandom), 1, 0);
                    else do_rd(2'($urandom), 1);
                end
                default: do_wr(2'($urandom), 8'($urandom), 0, 1);
            endcase
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule